// File: doc/BRIEF.md
# Multiplexed Display Refresh Controller

This block stores the coded characters of a multiplexed digit display in a 16-location, 8-bit-wide internal RAM and refreshes the display one digit at a time. A free-running scan sequencer selects the active digit; on every clock the byte held at that location is driven out as two 4-bit ports (`seg_hi`, `seg_lo`). The same byte is also available as one 8-bit port (`seg_byte`), so a board can wire either form. The digit count is 8 or 16, and the scan index wraps at the chosen count.

A host writes through a one-byte port. Each write is either a data byte or a control byte, chosen by `host_ctl`. The top three bits of a control byte pick the operation. The host can do five things: set the digit count; load a write pointer that can step on its own after each data write; protect either 4-bit half of a location from data writes; blank either half of the output; and start a clear sweep. The sweep zeroes the whole RAM, one location per clock. While it runs, `busy` is high and every host write is dropped.

For one clock at the start of every digit, both halves are forced to zero. This stops the previous digit's pattern from ghosting onto the newly selected one.

Top module: `disp_refresh_ctrl`

## Requirements
- R1: After reset, `seg_hi`, `seg_lo`, `digit_sel` and `busy` are all zero, every RAM location reads as zero, the digit count is 8 and auto-increment is off.
- R2: A data write (`host_wr`=1, `host_ctl`=0) stores `host_data` at the write pointer. With auto-increment on, the pointer then advances by one and wraps from 15 to 0.
- R3: `digit_sel` advances once every DIGIT_TICKS clocks. In 8-digit mode it wraps from 7 to 0, in 16-digit mode from 15 to 0. Control opcode 3'b000 selects the mode: bit 0 = 1 means 16 digits, 0 means 8.
- R4: Outside the first clock of a digit, `seg_hi` equals bits 7:4 and `seg_lo` equals bits 3:0 of the RAM location selected by `digit_sel`, and `seg_byte` = {`seg_hi`,`seg_lo`}.
- R5: In the first clock after `digit_sel` changes, `seg_hi` and `seg_lo` are both zero.
- R6: Control opcode 3'b101 sets write protection: bit 3 protects bits 7:4 and bit 2 protects bits 3:0 of each location. A protected half keeps its old value on a data write.
- R7: Control opcode 3'b101 also sets blanking: bit 1 forces `seg_hi` to zero and bit 0 forces `seg_lo` to zero.
- R8: Control opcode 3'b110 starts a clear. `busy` is high from the next clock for exactly 16 clocks, and all 16 locations end at zero. Data and control writes accepted while `busy` is high have no effect, and the write pointer does not change.
- R9: Control bytes with opcode 3'b001, 3'b010, 3'b011 or 3'b111 change neither the RAM, the pointer, the mode nor the masks.
- R10: Control opcode 3'b100 loads the write pointer from bits 3:0 and sets auto-increment from bit 4. With auto-increment off, repeated data writes all land at the same location.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe, one byte per clock |
| host_ctl | input | 1 | 1: byte is a control word, 0: byte is display data |
| host_data | input | 8 | Host byte |
| seg_hi | output | 4 | Upper half of the refreshed digit code |
| seg_lo | output | 4 | Lower half of the refreshed digit code |
| seg_byte | output | 8 | Both halves as one port |
| digit_sel | output | 4 | Index of the digit being refreshed |
| busy | output | 1 | Clear sweep in progress |

## Verification
The assertions watch the cycle-level rules on every clock. After every scan step the outputs must be zero for one clock. The index must either step by one or return to zero, and in 8-digit mode it must stay below 8. A blanked half must read zero. A clear sweep must last exactly 16 clocks, with the write pointer frozen throughout. Only the bench scenarios can show the stored contents: that each location holds what the host wrote under the active protection mask, that the pointer wraps and jumps as commanded, that unused opcodes leave everything unchanged, and that writes dropped during a clear leave the RAM at zero.

// File: rtl/disp_refresh_pkg.sv
package disp_refresh_pkg;

  typedef enum logic [2:0] {
    OP_MODE  = 3'b000,
    OP_PTR   = 3'b100,
    OP_MASK  = 3'b101,
    OP_CLEAR = 3'b110
  } disp_op_e;

  // Opcode sits in the top three bits of a control byte.
  function automatic logic [2:0] op_of(input logic [7:0] b);
    return b[7:5];
  endfunction

  // Step an index by one, returning to zero past the last legal value.
  function automatic int unsigned wrap_inc(input int unsigned v, input int unsigned last);
    return (v >= last) ? 0 : v + 1;
  endfunction

  // Last scan index for the selected digit count.
  function automatic int unsigned last_digit(input logic wide, input int unsigned num_loc);
    return wide ? num_loc - 1 : (num_loc / 2) - 1;
  endfunction

endpackage

// File: rtl/disp_host_if.sv
module disp_host_if
  import disp_refresh_pkg::*;
#(
  parameter int NUM_LOC = 16,
  localparam int ADDR_W = $clog2(NUM_LOC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic              host_ctl,
  input  logic [7:0]        host_data,
  output logic              digits16,
  output logic [ADDR_W-1:0] wr_ptr,
  output logic              wr_en_hi,
  output logic              wr_en_lo,
  output logic              blank_hi,
  output logic              blank_lo,
  output logic              busy,
  output logic [ADDR_W-1:0] clr_addr
);

  logic accept, ctl_evt, data_evt;
  logic autoinc, prot_hi, prot_lo;
  logic [2:0] op;

  assign accept   = host_wr & ~busy;
  assign ctl_evt  = accept & host_ctl;
  assign data_evt = accept & ~host_ctl;
  assign op       = op_of(host_data);

  assign wr_en_hi = data_evt & ~prot_hi;
  assign wr_en_lo = data_evt & ~prot_lo;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      digits16 <= 1'b0;
      wr_ptr   <= '0;
      autoinc  <= 1'b0;
      prot_hi  <= 1'b0;
      prot_lo  <= 1'b0;
      blank_hi <= 1'b0;
      blank_lo <= 1'b0;
      busy     <= 1'b0;
      clr_addr <= '0;
    end else begin
      if (ctl_evt) begin
        case (op)
          OP_MODE:  digits16 <= host_data[0];
          OP_PTR: begin
            wr_ptr  <= host_data[ADDR_W-1:0];
            autoinc <= host_data[4];
          end
          OP_MASK: begin
            prot_hi  <= host_data[3];
            prot_lo  <= host_data[2];
            blank_hi <= host_data[1];
            blank_lo <= host_data[0];
          end
          OP_CLEAR: begin
            busy     <= 1'b1;
            clr_addr <= '0;
          end
          default: ;
        endcase
      end
      if (data_evt && autoinc)
        wr_ptr <= ADDR_W'(wrap_inc(int'(wr_ptr), NUM_LOC - 1));
      if (busy) begin
        clr_addr <= ADDR_W'(wrap_inc(int'(clr_addr), NUM_LOC - 1));
        if (int'(clr_addr) == NUM_LOC - 1)
          busy <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/disp_nibble_ram.sv
module disp_nibble_ram #(
  parameter int NUM_LOC = 16,
  parameter int HALF_W  = 4,
  localparam int ADDR_W = $clog2(NUM_LOC),
  localparam int WORD_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic              clr,
  input  logic [ADDR_W-1:0] caddr,
  input  logic [ADDR_W-1:0] raddr,
  output logic [WORD_W-1:0] rdata
);

  // Index 0 is the lower half, index 1 the upper half; each is its own array.
  for (genvar h = 0; h < 2; h++) begin : g_half
    logic [HALF_W-1:0] mem [NUM_LOC];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        for (int i = 0; i < NUM_LOC; i++) mem[i] <= '0;
      end else if (clr) begin
        mem[caddr] <= '0;
      end else if (we[h]) begin
        mem[waddr] <= wdata[h*HALF_W +: HALF_W];
      end
    end

    assign rdata[h*HALF_W +: HALF_W] = mem[raddr];
  end

endmodule

// File: rtl/disp_scan_seq.sv
module disp_scan_seq
  import disp_refresh_pkg::*;
#(
  parameter int NUM_LOC     = 16,
  parameter int DIGIT_TICKS = 4,
  localparam int ADDR_W = $clog2(NUM_LOC),
  localparam int TICK_W = $clog2(DIGIT_TICKS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              digits16,
  output logic [ADDR_W-1:0] idx,
  output logic              gap,
  output logic              step
);

  logic [TICK_W-1:0] tick;

  assign step = (int'(tick) == DIGIT_TICKS - 1);
  assign gap  = (tick == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tick <= '0;
      idx  <= '0;
    end else if (step) begin
      tick <= '0;
      idx  <= ADDR_W'(wrap_inc(int'(idx), last_digit(digits16, NUM_LOC)));
    end else begin
      tick <= tick + 1'b1;
    end
  end

endmodule

// File: rtl/disp_refresh_ctrl.sv
module disp_refresh_ctrl #(
  parameter int NUM_LOC     = 16,
  parameter int HALF_W      = 4,
  parameter int DIGIT_TICKS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                host_wr,
  input  logic                host_ctl,
  input  logic [7:0]          host_data,
  output logic [HALF_W-1:0]   seg_hi,
  output logic [HALF_W-1:0]   seg_lo,
  output logic [2*HALF_W-1:0] seg_byte,
  output logic [$clog2(NUM_LOC)-1:0] digit_sel,
  output logic                busy
);

  localparam int ADDR_W = $clog2(NUM_LOC);

  logic              digits16, blank_hi, blank_lo;
  logic              wr_en_hi, wr_en_lo;
  logic [ADDR_W-1:0] wr_ptr, clr_addr;
  logic              scan_gap, scan_step;
  logic [2*HALF_W-1:0] rd_word;

  disp_host_if #(.NUM_LOC(NUM_LOC)) host_i (
    .clk(clk), .rst_n(rst_n),
    .host_wr(host_wr), .host_ctl(host_ctl), .host_data(host_data),
    .digits16(digits16), .wr_ptr(wr_ptr),
    .wr_en_hi(wr_en_hi), .wr_en_lo(wr_en_lo),
    .blank_hi(blank_hi), .blank_lo(blank_lo),
    .busy(busy), .clr_addr(clr_addr)
  );

  disp_nibble_ram #(.NUM_LOC(NUM_LOC), .HALF_W(HALF_W)) ram_i (
    .clk(clk), .rst_n(rst_n),
    .we({wr_en_hi, wr_en_lo}), .waddr(wr_ptr),
    .wdata(host_data[2*HALF_W-1:0]),
    .clr(busy), .caddr(clr_addr),
    .raddr(digit_sel), .rdata(rd_word)
  );

  disp_scan_seq #(.NUM_LOC(NUM_LOC), .DIGIT_TICKS(DIGIT_TICKS)) scan_i (
    .clk(clk), .rst_n(rst_n), .digits16(digits16),
    .idx(digit_sel), .gap(scan_gap), .step(scan_step)
  );

  assign seg_hi   = (scan_gap || blank_hi) ? '0 : rd_word[2*HALF_W-1:HALF_W];
  assign seg_lo   = (scan_gap || blank_lo) ? '0 : rd_word[HALF_W-1:0];
  assign seg_byte = {seg_hi, seg_lo};

endmodule

// File: rtl/disp_refresh_chk.sv
module disp_refresh_chk #(
  parameter int NUM_LOC = 16,
  parameter int HALF_W  = 4,
  localparam int ADDR_W = $clog2(NUM_LOC),
  localparam int CNT_W  = $clog2(NUM_LOC) + 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              scan_step,
  input logic              digits16,
  input logic              blank_hi,
  input logic              blank_lo,
  input logic [ADDR_W-1:0] wr_ptr,
  input logic [ADDR_W-1:0] digit_sel,
  input logic [HALF_W-1:0] seg_hi,
  input logic [HALF_W-1:0] seg_lo
);

  logic [CNT_W-1:0] busy_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)    busy_cnt <= '0;
    else if (busy) busy_cnt <= busy_cnt + 1'b1;
    else           busy_cnt <= '0;
  end

  assert_gap_blank_R5: assert property (@(posedge clk) disable iff (!rst_n)
    scan_step |=> (seg_hi == '0 && seg_lo == '0));

  assert_scan_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
    scan_step |=> (digit_sel == '0 || digit_sel == $past(digit_sel) + 1'b1));

  assert_scan_wrap8_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_step && !digits16) |=> (int'(digit_sel) < NUM_LOC / 2));

  assert_blank_hi_R7: assert property (@(posedge clk) disable iff (!rst_n)
    blank_hi |-> seg_hi == '0);

  assert_blank_lo_R7: assert property (@(posedge clk) disable iff (!rst_n)
    blank_lo |-> seg_lo == '0);

  assert_clear_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> int'(busy_cnt) == NUM_LOC);

  assert_clear_ptr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(wr_ptr));

endmodule

bind disp_refresh_ctrl disp_refresh_chk #(.NUM_LOC(NUM_LOC), .HALF_W(HALF_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy), .scan_step(scan_step),
  .digits16(digits16), .blank_hi(blank_hi), .blank_lo(blank_lo),
  .wr_ptr(wr_ptr), .digit_sel(digit_sel), .seg_hi(seg_hi), .seg_lo(seg_lo)
);

// File: tb/disp_refresh_ctrl_tb_top.sv
module disp_refresh_ctrl_tb_top;

  localparam int TICKS = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n, host_wr, host_ctl;
  logic [7:0] host_data;
  logic [3:0] seg_hi, seg_lo, digit_sel;
  logic [7:0] seg_byte;
  logic       busy;

  disp_refresh_ctrl #(.NUM_LOC(16), .HALF_W(4), .DIGIT_TICKS(TICKS)) dut_i (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_ctl(host_ctl),
    .host_data(host_data), .seg_hi(seg_hi), .seg_lo(seg_lo),
    .seg_byte(seg_byte), .digit_sel(digit_sel), .busy(busy)
  );

  int n_chk = 0, n_fail = 0;

  typedef struct {
    int         idx;
    logic [3:0] hi;
    logic [3:0] lo;
    string      req;
  } exp_t;
  exp_t sb[$];

  // Bench-side model of the stored bytes and host-visible settings.
  logic [7:0] m_ram [16];
  int  m_ptr = 0, n_dig = 8;
  bit  m_auto = 0, m_ph = 0, m_pl = 0, m_bh = 0, m_bl = 0;
  bit  settled = 1, run_mon = 0, seen_step = 0;
  int  prev_idx = 0, cyc = 0;

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic send(bit ctl, logic [7:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_ctl = ctl; host_data = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic host_write(logic [7:0] d);
    send(1'b0, d);
    if (!m_ph) m_ram[m_ptr][7:4] = d[7:4];
    if (!m_pl) m_ram[m_ptr][3:0] = d[3:0];
    if (m_auto) m_ptr = (m_ptr + 1) % 16;
  endtask

  task automatic set_mask(bit ph, bit pl, bit bh, bit bl);
    send(1'b1, {3'b101, 1'b0, ph, pl, bh, bl});
    m_ph = ph; m_pl = pl; m_bh = bh; m_bl = bl;
  endtask

  task automatic set_ptr(int a, bit au);
    send(1'b1, {3'b100, au, 4'(a)});
    m_ptr = a; m_auto = au;
  endtask

  task automatic set_mode(bit wide);
    settled = 0;
    send(1'b1, {7'b0, wide});
    n_dig = wide ? 16 : 8;
    settled = 0;
  endtask

  // Driver: queue one expected item per active digit, then wait for the monitor.
  task automatic expect_all(string req);
    for (int i = 0; i < n_dig; i++) begin
      exp_t e;
      e.idx = i;
      e.hi  = m_bh ? 4'h0 : m_ram[i][7:4];
      e.lo  = m_bl ? 4'h0 : m_ram[i][3:0];
      e.req = req;
      sb.push_back(e);
    end
    while (sb.size() != 0) @(negedge clk);
  endtask

  // Monitor: scan order, gap blanking and scoreboard comparison.
  always @(negedge clk) begin
    if (run_mon) begin
      if (int'(digit_sel) != prev_idx) begin
        check(seg_hi == 4'h0 && seg_lo == 4'h0, "R5", "gap blank",
              int'({seg_hi, seg_lo}), 0);
        if (settled) begin
          check(int'(digit_sel) == ((prev_idx >= n_dig - 1) ? 0 : prev_idx + 1),
                "R3", "next digit", int'(digit_sel),
                (prev_idx >= n_dig - 1) ? 0 : prev_idx + 1);
        end else begin
          check(digit_sel == 4'd0 || int'(digit_sel) == prev_idx + 1,
                "R3", "next digit", int'(digit_sel), prev_idx + 1);
          if (digit_sel == 4'd0) settled = 1;
        end
        if (seen_step)
          check(cyc == TICKS, "R3", "digit period", cyc, TICKS);
        seen_step = 1;
        cyc = 1;
        prev_idx = int'(digit_sel);
      end else begin
        cyc++;
        if (sb.size() != 0 && sb[0].idx == int'(digit_sel)) begin
          exp_t e;
          e = sb.pop_front();
          check(seg_hi == e.hi, e.req, $sformatf("hi digit %0d", e.idx), int'(seg_hi), int'(e.hi));
          check(seg_lo == e.lo, e.req, $sformatf("lo digit %0d", e.idx), int'(seg_lo), int'(e.lo));
          check(seg_byte == {e.hi, e.lo}, "R4", $sformatf("byte digit %0d", e.idx),
                int'(seg_byte), int'({e.hi, e.lo}));
        end
      end
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 16; i++) m_ram[i] = 8'h00;
    rst_n = 1'b0; host_wr = 1'b0; host_ctl = 1'b0; host_data = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state seen at the ports.
    check(seg_hi == 4'h0 && seg_lo == 4'h0, "R1", "segments", int'(seg_byte), 0);
    check(digit_sel == 4'd0, "R1", "digit_sel", int'(digit_sel), 0);
    check(busy == 1'b0, "R1", "busy", int'(busy), 0);
    prev_idx = 0; cyc = 0; run_mon = 1;
    expect_all("R1");

    // R2: auto-increment fill of the 8 active digits.
    set_ptr(0, 1);
    for (int i = 0; i < 8; i++) host_write(8'((i * 37 + 5) & 8'hFF));
    expect_all("R2");

    // R2: pointer wraps from 15 to 0; R3: 16-digit mode.
    set_ptr(15, 1);
    host_write(8'h7E);
    host_write(8'h81);
    set_mode(1'b1);
    expect_all("R3");

    // R10: pointer load with auto-increment off.
    set_ptr(5, 0);
    host_write(8'h12);
    host_write(8'h34);
    expect_all("R10");

    // R6: protect upper half, then lower half.
    set_mask(1, 0, 0, 0);
    host_write(8'hFF);
    expect_all("R6");
    set_mask(0, 1, 0, 0);
    host_write(8'h90);
    expect_all("R6");
    set_mask(0, 0, 0, 0);

    // R7: blank each half in turn.
    set_mask(0, 0, 1, 0);
    expect_all("R7");
    set_mask(0, 0, 0, 1);
    expect_all("R7");
    set_mask(0, 0, 0, 0);

    // R9: unused opcodes leave everything as it was.
    send(1'b1, 8'h3F);
    send(1'b1, 8'h5F);
    send(1'b1, 8'h7F);
    send(1'b1, 8'hFF);
    host_write(8'h66);
    expect_all("R9");

    // R3: back to 8 digits.
    set_mode(1'b0);
    expect_all("R3");

    // R8: clear sweep, with writes attempted while busy.
    set_ptr(3, 1);
    send(1'b1, 8'hC0);
    check(busy == 1'b1, "R8", "busy after clear", int'(busy), 1);
    begin
      int bc = 0;
      for (int k = 0; k < 40; k++) begin
        if (busy) bc++;
        host_wr   = (k == 1 || k == 3);
        host_ctl  = (k == 1);
        host_data = (k == 1) ? 8'h89 : 8'h55;
        @(negedge clk);
      end
      host_wr = 1'b0;
      check(bc == 16, "R8", "busy length", bc, 16);
    end
    for (int i = 0; i < 16; i++) m_ram[i] = 8'h00;
    expect_all("R8");
    host_write(8'hAB);
    host_write(8'hCD);
    expect_all("R8");

    repeat (20) @(negedge clk);
    finish_run();
  end

endmodule